// File: doc/BRIEF.md
# Refresh and Low-Power Mode Controller

This block sits beside the command sequencer of a DDR SDRAM controller. It owns three jobs: it keeps the memory refreshed at a programmable interval, it puts the memory into power-down or self-refresh when the user asks, and it drives the clock-enable pin (`cke_o`). It never drives the command bus on its own authority. Whenever it needs the bus, it raises `req_o` and waits for `gnt_i`. The sequencer asserts `gnt_i` only while it is idle with every bank precharged, and it holds `gnt_i` for as long as `req_o` stays high.

User commands arrive on `cmd_valid_i`/`cmd_i`. Power commands toggle their mode: `101` for power-down and `110` for self-refresh. All other commands pass straight through to the sequencer on `usr_valid_o`/`usr_cmd_o`, unless a low-power mode is pending or active. In that case they are dropped.

While the memory is in power-down, refresh does not stop. When the interval expires, the block raises CKE for one NOP cycle, issues AUTO REFRESH, waits out the refresh period, and drops CKE again. In self-refresh the memory refreshes itself, so the interval timer is frozen. On self-refresh exit the block holds the bus for a fixed number of NOP cycles, then restarts the timer from a full interval.

Top module: `rfsh_lp_ctrl`

## Requirements
- R1: While `rst_ni` is low, `cke_o` is 1, and `aref_o` and `req_o` are 0.
- R2: The refresh timer counts `refi_i` cycles, starting from reset release or from the cycle an AUTO REFRESH begins. It then requests the bus. If the grant returns one cycle after the request, refreshes in normal mode start exactly `refi_i`+2 cycles apart.
- R3: AUTO REFRESH is a single-cycle `aref_o` pulse. It is followed by `trfc_i` cycles of NOP with the bus held, after which `req_o` falls.
- R4: A command of 3'b101 outside low-power mode requests power-down. After the grant, `cke_o` drops with no `aref_o`. A second 3'b101 while in power-down raises `cke_o` on the next cycle and releases the bus.
- R5: A command of 3'b110 outside low-power mode requests self-refresh. Entry is `aref_o` high with `cke_o` low in the same cycle. `cke_o` then stays low, and no further refresh is issued until exit.
- R6: A second 3'b110 while in self-refresh raises `cke_o` on the next cycle. The bus is then held for `XSR_NOPS` cycles of NOP, after which `req_o` falls. The next refresh starts `refi_i`+2 cycles after that release.
- R7: In power-down, when the interval expires, `cke_o` rises for exactly one NOP cycle. AUTO REFRESH follows, and `cke_o` falls again `trfc_i`+1 cycles after the refresh cycle.
- R8: Power commands (3'b101, 3'b110) are never forwarded. Every other command is forwarded combinationally in normal mode. From the cycle an entry is accepted until the bus is released after exit, nothing is forwarded.
- R9: When a refresh and a low-power entry are both pending at the grant, the refresh runs first and the entry follows once it completes.
- R10: If the power-down exit command arrives on the same cycle the interval expires, the exit is taken. The refresh is not lost: it runs on the next cycle with `cke_o` high, and the block does not return to power-down.
- R11: `req_o` is high in every cycle in which `cke_o` is low.
- R12: A power command is dropped in three cases: when an entry is already pending, during a refresh or wake sequence, or during the self-refresh exit NOPs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | User command valid |
| cmd_i | input | 3 | User command code |
| refi_i | input | CNT_W | Refresh interval in cycles |
| trfc_i | input | TRFC_W | Cycles of NOP after each AUTO REFRESH |
| gnt_i | input | 1 | Bus granted by the command sequencer |
| req_o | output | 1 | Bus request to the command sequencer |
| cke_o | output | 1 | Memory clock enable |
| aref_o | output | 1 | AUTO REFRESH command (self-refresh entry when `cke_o` is low) |
| usr_valid_o | output | 1 | Forwarded user command valid |
| usr_cmd_o | output | 3 | Forwarded user command code |

## Verification
The two functions that can fall in the same cycle are the interval expiry and the user's power-down exit command. The bench measures the exact cycle of the previous refresh. It then drives the 3'b101 exit so that it is sampled on the edge at which the expired timer would start a wake. The scoreboard expects, in order and at fixed cycles, a CKE rise and then a normal AUTO REFRESH with CKE high. After that it expects no return to power-down, with the bus released `trfc_i`+1 cycles later. A second collision, a pending refresh against a pending power-down entry, is set up by withholding the grant until both are waiting.

// File: rtl/rlp_pkg.sv
package rlp_pkg;
  localparam logic [2:0] CMD_PWR_DOWN = 3'b101;
  localparam logic [2:0] CMD_SELF_REF = 3'b110;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_AREF,
    ST_RFC,
    ST_PD,
    ST_PD_WAKE,
    ST_SR_IN,
    ST_SR,
    ST_SR_OUT
  } rlp_state_e;
endpackage

// File: rtl/rlp_refi_timer.sv
module rlp_refi_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] refi_i,
  input  logic             reload_i,
  input  logic             freeze_i,
  output logic             due_o
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  // first cycle after reset loads the interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q || reload_i) begin
      armed_q <= 1'b1;
      cnt_q   <= refi_i;
    end else if (!freeze_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign due_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/rlp_wait_cnt.sv
module rlp_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // a load of 0 behaves as 1
  assign done_o = (cnt_q <= W'(1));
endmodule

// File: rtl/rlp_lp_fsm.sv
module rlp_lp_fsm
  import rlp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_pd_i,
  input  logic pwr_sr_i,
  input  logic gnt_i,
  input  logic ref_due_i,
  input  logic wait_done_i,
  output logic req_o,
  output logic cke_o,
  output logic aref_o,
  output logic lp_mode_o,
  output logic reload_o,
  output logic freeze_o,
  output logic wait_ld_o,
  output logic wait_xsr_o
);
  rlp_state_e state_q, state_n;
  logic pd_req_q, sr_req_q, pd_ctx_q;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RUN: if (gnt_i) begin
        if (ref_due_i)      state_n = ST_AREF;
        else if (pd_req_q)  state_n = ST_PD;
        else if (sr_req_q)  state_n = ST_SR_IN;
      end
      ST_AREF:    state_n = ST_RFC;
      ST_RFC:     if (wait_done_i) state_n = pd_ctx_q ? ST_PD : ST_RUN;
      ST_PD:      if (pwr_pd_i) state_n = ST_RUN;
                  else if (ref_due_i) state_n = ST_PD_WAKE;
      ST_PD_WAKE: state_n = ST_AREF;
      ST_SR_IN:   state_n = ST_SR;
      ST_SR:      if (pwr_sr_i) state_n = ST_SR_OUT;
      ST_SR_OUT:  if (wait_done_i) state_n = ST_RUN;
      default:    state_n = ST_RUN;
    endcase
  end

  assign lp_mode_o = pd_req_q || sr_req_q || pd_ctx_q ||
                     (state_q inside {ST_PD, ST_PD_WAKE, ST_SR_IN, ST_SR, ST_SR_OUT});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      pd_req_q <= 1'b0;
      sr_req_q <= 1'b0;
      pd_ctx_q <= 1'b0;
    end else begin
      state_q <= state_n;
      if (state_q == ST_RUN && !lp_mode_o) begin
        pd_req_q <= pwr_pd_i;
        sr_req_q <= pwr_sr_i && !pwr_pd_i;
      end else begin
        if (state_n == ST_PD)    pd_req_q <= 1'b0;
        if (state_n == ST_SR_IN) sr_req_q <= 1'b0;
      end
      if (state_n == ST_PD)       pd_ctx_q <= 1'b1;
      else if (state_n == ST_RUN) pd_ctx_q <= 1'b0;
    end
  end

  assign req_o      = (state_q != ST_RUN) || ref_due_i || pd_req_q || sr_req_q;
  assign cke_o      = !(state_q inside {ST_PD, ST_SR_IN, ST_SR});
  assign aref_o     = (state_q == ST_AREF) || (state_q == ST_SR_IN);
  assign reload_o   = (state_n == ST_AREF && state_q != ST_AREF) ||
                      (state_q == ST_SR_OUT && state_n == ST_RUN);
  assign freeze_o   = state_q inside {ST_SR_IN, ST_SR, ST_SR_OUT};
  assign wait_ld_o  = (state_q == ST_AREF) || (state_q == ST_SR && pwr_sr_i);
  assign wait_xsr_o = (state_q == ST_SR);
endmodule

// File: rtl/rfsh_lp_ctrl.sv
module rfsh_lp_ctrl
  import rlp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TRFC_W   = 4,
  parameter int XSR_NOPS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [CNT_W-1:0]  refi_i,
  input  logic [TRFC_W-1:0] trfc_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic              cke_o,
  output logic              aref_o,
  output logic              usr_valid_o,
  output logic [2:0]        usr_cmd_o
);
  localparam int XSR_W  = $clog2(XSR_NOPS + 1);
  localparam int WAIT_W = (TRFC_W > XSR_W) ? TRFC_W : XSR_W;

  logic pwr_pd, pwr_sr, ref_due, wait_done, lp_mode;
  logic reload, freeze, wait_ld, wait_xsr;
  logic [WAIT_W-1:0] wait_val;

  assign pwr_pd = cmd_valid_i && (cmd_i == CMD_PWR_DOWN);
  assign pwr_sr = cmd_valid_i && (cmd_i == CMD_SELF_REF);

  rlp_refi_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .refi_i   (refi_i),
    .reload_i (reload),
    .freeze_i (freeze),
    .due_o    (ref_due)
  );

  assign wait_val = wait_xsr ? WAIT_W'(XSR_NOPS) : WAIT_W'(trfc_i);

  rlp_wait_cnt #(.W(WAIT_W)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wait_ld),
    .val_i  (wait_val),
    .done_o (wait_done)
  );

  rlp_lp_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_pd_i    (pwr_pd),
    .pwr_sr_i    (pwr_sr),
    .gnt_i       (gnt_i),
    .ref_due_i   (ref_due),
    .wait_done_i (wait_done),
    .req_o       (req_o),
    .cke_o       (cke_o),
    .aref_o      (aref_o),
    .lp_mode_o   (lp_mode),
    .reload_o    (reload),
    .freeze_o    (freeze),
    .wait_ld_o   (wait_ld),
    .wait_xsr_o  (wait_xsr)
  );

  assign usr_valid_o = cmd_valid_i && !lp_mode && !pwr_pd && !pwr_sr;
  assign usr_cmd_o   = cmd_i;
endmodule

// File: rtl/rlp_chk.sv
module rlp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [2:0] cmd_i,
  input logic       gnt_i,
  input logic       req_o,
  input logic       cke_o,
  input logic       aref_o,
  input logic       usr_valid_o
);
  AST_AREF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aref_o |=> !aref_o); // R3
  AST_AREF_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aref_o |-> gnt_i); // R2
  AST_CKE_DROP_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> gnt_i); // R4
  AST_CKE_LOW_HOLDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> req_o); // R11
  AST_NO_PWR_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usr_valid_o |-> (cmd_valid_i && cmd_i != 3'b101 && cmd_i != 3'b110)); // R8
  AST_SR_NO_AREF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && $past(!cke_o)) |-> !aref_o); // R5
endmodule

bind rfsh_lp_ctrl rlp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .gnt_i       (gnt_i),
  .req_o       (req_o),
  .cke_o       (cke_o),
  .aref_o      (aref_o),
  .usr_valid_o (usr_valid_o)
);

// File: tb/sim_rfsh_lp_ctrl.sv
module sim_rfsh_lp_ctrl;
  localparam int REFI = 60;
  localparam int TRFC = 9;
  localparam int XSR  = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [15:0] refi_i = 16'(REFI);
  logic [3:0] trfc_i = 4'(TRFC);
  logic gnt_i;
  logic req_o, cke_o, aref_o, usr_valid_o;
  logic [2:0] usr_cmd_o;

  always #10 clk_i = ~clk_i;

  rfsh_lp_ctrl #(.CNT_W(16), .TRFC_W(4), .XSR_NOPS(XSR)) u0 (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i, .refi_i, .trfc_i, .gnt_i,
    .req_o, .cke_o, .aref_o, .usr_valid_o, .usr_cmd_o
  );

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit hold = 1'b0;
  bit done = 1'b0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // sequencer model: grant one cycle after request
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) gnt_i <= 1'b0;
    else         gnt_i <= req_o && !hold;

  typedef enum {EV_AREF, EV_SRE, EV_CKE_DN, EV_CKE_UP} ev_e;
  typedef struct {ev_e k; int c; string tag;} ev_s;
  ev_s exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(input ev_e k, input int c, input string tag);
    ev_s e;
    e.k = k; e.c = c; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic observe(input ev_e k);
    ev_s e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "unexpected event", int'(k), -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.k == k, {e.tag, " event kind"}, int'(k), int'(e.k));
      chk(e.c == cyc, {e.tag, " event cycle"}, cyc, e.c);
    end
  endtask

  // monitor
  bit prev_cke = 1'b1, prev_aref = 1'b0, prev_req = 1'b0;
  int req_fall = -1;
  int aref_cnt = 0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (aref_o && !prev_aref) begin
        if (cke_o) begin observe(EV_AREF); aref_cnt++; end
        else observe(EV_SRE);
      end
      if (!cke_o && prev_cke && !aref_o) observe(EV_CKE_DN);
      if (cke_o && !prev_cke) observe(EV_CKE_UP);
      if (prev_req && !req_o) req_fall = cyc;
    end
    prev_cke  = cke_o;
    prev_aref = aref_o;
    prev_req  = req_o;
  end

  task automatic step();
    @(posedge clk_i); #2;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) step();
  endtask

  // command sampled at edge t; returns forwarded flag
  task automatic drive_at(input int t, input logic [2:0] c, output bit fwd);
    while (cyc < t - 1) step();
    cmd_valid_i = 1'b1;
    cmd_i = c;
    #3;
    fwd = usr_valid_o;
    step();
    cmd_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int a, e1, e2, e3, e4, e5, p, t, s0, s1, h, x, n0;
    bit fwd;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(cke_o == 1'b1, "R1 cke in reset", cke_o, 1);
    chk(req_o == 1'b0, "R1 req in reset", req_o, 0);
    chk(aref_o == 1'b0, "R1 aref in reset", aref_o, 0);
    step();
    rst_ni = 1'b1;
    a  = cyc + 1;
    e1 = a + REFI + 2;
    e2 = e1 + REFI + 2;
    expect_ev(EV_AREF, e1, "R2 first refresh");
    expect_ev(EV_AREF, e2, "R2 periodic refresh");

    drive_at(cyc + 2, 3'b001, fwd);
    chk(fwd == 1'b1, "R8 read forwarded in normal mode", fwd, 1);
    drive_at(cyc + 2, 3'b111, fwd);
    chk(fwd == 1'b1, "R8 other cmd forwarded", fwd, 1);

    wait_until(e1 + TRFC + 3);
    chk(req_fall == e1 + 1 + TRFC, "R3 bus held for trfc", req_fall, e1 + 1 + TRFC);

    // power-down entry
    wait_until(e2 + TRFC + 3);
    p = cyc + 1;
    drive_at(p, 3'b101, fwd);
    chk(fwd == 1'b0, "R8 power-down cmd not forwarded", fwd, 0);
    expect_ev(EV_CKE_DN, p + 2, "R4 power-down entry");
    e3 = e2 + REFI + 2;
    expect_ev(EV_CKE_UP, e3 - 1, "R7 wake for refresh");
    expect_ev(EV_AREF, e3, "R7 refresh in power-down");
    expect_ev(EV_CKE_DN, e3 + 1 + TRFC, "R7 re-enter power-down");
    drive_at(p + 5, 3'b001, fwd);
    chk(fwd == 1'b0, "R8 read ignored in power-down", fwd, 0);
    drive_at(p + 6, 3'b110, fwd);
    chk(fwd == 1'b0, "R12 self-refresh cmd ignored in power-down", fwd, 0);
    wait_until(p + 8);
    chk(cke_o == 1'b0, "R4 cke low in power-down", cke_o, 0);

    // exit coincides with interval expiry
    t = e3 + REFI + 1;
    expect_ev(EV_CKE_UP, t, "R10 exit wins");
    expect_ev(EV_AREF, t + 1, "R10 refresh kept");
    drive_at(t, 3'b101, fwd);
    e4 = t + 1;
    wait_until(e4 + TRFC + 3);
    chk(req_fall == e4 + 1 + TRFC, "R10 bus released after refresh", req_fall, e4 + 1 + TRFC);
    chk(cke_o == 1'b1, "R10 no return to power-down", cke_o, 1);

    // self-refresh
    s0 = cyc + 1;
    drive_at(s0, 3'b110, fwd);
    chk(fwd == 1'b0, "R8 self-refresh cmd not forwarded", fwd, 0);
    expect_ev(EV_SRE, s0 + 2, "R5 self-refresh entry");
    n0 = aref_cnt;
    drive_at(s0 + 20, 3'b010, fwd);
    chk(fwd == 1'b0, "R8 write ignored in self-refresh", fwd, 0);
    wait_until(s0 + 3 * REFI);
    chk(cke_o == 1'b0, "R5 cke low in self-refresh", cke_o, 0);
    chk(aref_cnt == n0, "R5 no refresh in self-refresh", aref_cnt, n0);
    s1 = cyc + 1;
    expect_ev(EV_CKE_UP, s1, "R6 self-refresh exit");
    drive_at(s1, 3'b110, fwd);
    drive_at(s1 + 2, 3'b110, fwd);
    chk(fwd == 1'b0, "R12 cmd during exit NOPs", fwd, 0);
    drive_at(s1 + 3, 3'b001, fwd);
    chk(fwd == 1'b0, "R8 read ignored during exit NOPs", fwd, 0);
    wait_until(s1 + XSR + 2);
    chk(req_fall == s1 + XSR, "R6 exit NOP count", req_fall, s1 + XSR);
    chk(cke_o == 1'b1, "R12 no re-entry after dropped cmd", cke_o, 1);
    e5 = s1 + XSR + REFI + 2;
    expect_ev(EV_AREF, e5, "R6 timer restarts after exit");

    // refresh vs pending entry
    wait_until(e5 + TRFC + 3);
    hold = 1'b1;
    drive_at(cyc + 1, 3'b101, fwd);
    drive_at(cyc + 1, 3'b110, fwd);
    wait_until(e5 + REFI + 5);
    chk(req_o == 1'b1, "R9 request while grant withheld", req_o, 1);
    h = cyc;
    expect_ev(EV_AREF, h + 2, "R9 refresh first");
    expect_ev(EV_CKE_DN, h + 4 + TRFC, "R9 entry after refresh");
    hold = 1'b0;
    wait_until(h + TRFC + 7);
    x = cyc + 1;
    expect_ev(EV_CKE_UP, x, "R4 power-down exit");
    drive_at(x, 3'b101, fwd);
    wait_until(x + 4);
    chk(req_o == 1'b0, "R4 bus released after exit", req_o, 0);
    chk(cke_o == 1'b1, "R12 second entry dropped", cke_o, 1);
    wait_until(x + 8);
    chk(exp_q.size() == 0, "all expected events seen", exp_q.size(), 0);
    finish_run();
  end
endmodule